// File: doc/BRIEF.md
# Wait-for-event / wait-for-interrupt sleep controller

This block sits beside a core's execute stage and settles what happens when the core retires a wait instruction. There are two kinds: wait-for-event (WFE) and wait-for-interrupt (WFI). Each accepted wait instruction gets exactly one outcome. The core either carries on at once (a skip), takes a trap to one of three handler levels with a fixed syndrome, or goes into a low-power sleep state. It stays in that state until a wake condition arrives.

The controller keeps a one-bit event flag. Send-event strobes set it, and so does an external event line, and a WFE consumes it. Before a sleep is allowed, a fixed-priority chain of trap checks runs: a supervisor trap for unprivileged code, then a hypervisor trap for non-secure guests, then a secure-monitor trap. The execution-level, security and trap-enable inputs are sampled in the cycle the instruction is presented. All outcome outputs are registered and appear in the following cycle.

Top module: `wait_sleep_ctrl`

## Requirements
- R1: During and just after reset, `sleep_o`, `event_o`, `skip_o`, `trap_o` and `abort_clr_o` are 0, and `trap_level_o`, `trap_syndrome_o` and `trap_class_o` are 0.
- R2: A WFE (`instr_is_wfi`=0) accepted while the event flag is 1 skips, whatever the trap controls are, and clears the flag.
- R3: A WFE accepted with the flag at 0 and `irq_pend_unmasked`=1 skips. A pending interrupt that is only masked does not stop a WFE.
- R4: A WFI (`instr_is_wfi`=1) accepted with `irq_pend_any`=1 skips, whether or not the interrupt is masked.
- R5: If no skip applies and `cur_el` is 0 with the matching EL0 permit bit clear, a supervisor trap is taken, level code 1. This check wins over the hypervisor and monitor checks.
- R6: Otherwise, if virtualization is present, the core is non-secure, it is not in hypervisor mode and the matching hypervisor trap bit is set, a hypervisor trap is taken, level code 2.
- R7: Otherwise, if security is present, `cur_el` is not the top level (all ones) and the matching monitor trap bit is set, a secure-monitor trap is taken, level code 3.
- R8: Every trap drives `trap_syndrome_o` to 0x1E00001 for WFE and 0x1E00000 for WFI, and `trap_class_o` to 0x01. When no trap is signalled, all three trap outputs read 0.
- R9: If no skip or trap applies, the block sleeps. `sleep_o` rises in the next cycle and stays high until a wake. Instructions presented while asleep are ignored.
- R10: A WFI sleep wakes on `irq_pend_any`. A WFE sleep wakes on `irq_pend_unmasked` or on any event strobe, and that strobe is absorbed, so the flag stays 0. `sleep_o` falls in the cycle after the wake input.
- R11: `sev_strobe`, `sevl_strobe` and `ext_event` set the event flag, except when they wake a WFE sleep. A strobe in the same cycle as a WFE that consumes the flag leaves it at 1.
- R12: `abort_clr_o` pulses for one cycle after each WFI that skips or traps, and after each wake from a WFI sleep.
- R13: `skip_o` and `trap_o` are one-cycle results of a single accepted instruction. They are never high together and never high while `sleep_o` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| instr_valid | input | 1 | A wait instruction is presented this cycle |
| instr_is_wfi | input | 1 | 1 = WFI, 0 = WFE |
| sev_strobe | input | 1 | Send-event strobe |
| sevl_strobe | input | 1 | Local send-event strobe |
| ext_event | input | 1 | External event input |
| cur_el | input | EL_W | Current exception level |
| in_secure | input | 1 | Core is in secure state |
| in_hyp_mode | input | 1 | Core is in hypervisor mode |
| virt_present | input | 1 | Virtualization support present |
| sec_present | input | 1 | Security support present |
| el0_wfe_ok | input | 1 | WFE permitted at EL0 without a trap |
| el0_wfi_ok | input | 1 | WFI permitted at EL0 without a trap |
| hyp_wfe_trap | input | 1 | Hypervisor traps WFE |
| hyp_wfi_trap | input | 1 | Hypervisor traps WFI |
| mon_wfe_trap | input | 1 | Monitor traps WFE |
| mon_wfi_trap | input | 1 | Monitor traps WFI |
| irq_pend_unmasked | input | 1 | An unmasked interrupt is pending |
| irq_pend_any | input | 1 | Any interrupt, masked or not, is pending |
| skip_o | output | 1 | Instruction completes without sleep |
| trap_o | output | 1 | Instruction traps |
| trap_level_o | output | 2 | 1 supervisor, 2 hypervisor, 3 monitor |
| trap_syndrome_o | output | SYN_W | Trap syndrome value |
| trap_class_o | output | EC_W | Trap exception class |
| sleep_o | output | 1 | Core is asleep |
| event_o | output | 1 | Event flag |
| abort_clr_o | output | 1 | Clear pending asynchronous abort |

## Verification
The checker assumes that `irq_pend_unmasked` never rises without `irq_pend_any`, because an unmasked pending interrupt is also a pending one. Its wake property for both sleep kinds relies on that. Every stimulus pattern, both the directed ones and the pseudo-random ones, forces `irq_pend_any` high whenever the unmasked line is high. The checker also takes the per-kind control bits to be stable within a cycle. The bench drives all inputs on the falling edge so that this holds.

// File: rtl/wsc_pkg.sv
package wsc_pkg;

    localparam int unsigned WSC_SYN_BITS = 25;
    localparam int unsigned WSC_EC_BITS  = 6;
    localparam logic [31:0] WSC_SYN_BASE = 32'h01E0_0000;
    localparam logic [5:0]  WSC_EC_WAIT  = 6'h01;

    typedef enum logic [1:0] {
        ST_AWAKE    = 2'd0,
        ST_NAP_EVT  = 2'd1,
        ST_NAP_IRQ  = 2'd2
    } wsc_state_e;

    typedef enum logic [1:0] {
        LVL_NONE = 2'd0,
        LVL_SUP  = 2'd1,
        LVL_HYP  = 2'd2,
        LVL_MON  = 2'd3
    } wsc_lvl_e;

    typedef enum logic [1:0] {
        RES_SKIP  = 2'd0,
        RES_TRAP  = 2'd1,
        RES_SLEEP = 2'd2
    } wsc_result_e;

    typedef struct packed {
        wsc_result_e kind;
        wsc_lvl_e    lvl;
        logic        eat_event;
        logic        is_wfi;
    } wsc_verdict_t;

    function automatic logic kind_bit(input logic is_wfi);
        return ~is_wfi;
    endfunction

endpackage

// File: rtl/wsc_event_flag.sv
module wsc_event_flag (
    input  logic clk,
    input  logic rst,
    input  logic set_any,
    input  logic consume,
    input  logic absorb,
    output logic ev_q
);

    always_ff @(posedge clk) begin
        if (rst) begin
            ev_q <= 1'b0;
        end else if (absorb) begin
            ev_q <= 1'b0;
        end else if (set_any) begin
            ev_q <= 1'b1;
        end else if (consume) begin
            ev_q <= 1'b0;
        end
    end

endmodule

// File: rtl/wsc_trap_chain.sv
module wsc_trap_chain
    import wsc_pkg::*;
#(
    parameter int EL_W = 2
) (
    input  logic            is_wfi,
    input  logic            ev_q,
    input  logic            irq_unm,
    input  logic            irq_any,
    input  logic [EL_W-1:0] el,
    input  logic            secure,
    input  logic            hyp_mode,
    input  logic            has_virt,
    input  logic            has_sec,
    input  logic [1:0]      el0_ok,
    input  logic [1:0]      hyp_trap,
    input  logic [1:0]      mon_trap,
    output wsc_verdict_t    verdict
);

    localparam logic [EL_W-1:0] EL_LOW  = '0;
    localparam logic [EL_W-1:0] EL_HIGH = '1;

    logic [1:0] early, sup_hit, hyp_hit, mon_hit;

    for (genvar k = 0; k < 2; k++) begin : g_kind
        if (k == 0) begin : g_wfe
            assign early[k] = ev_q | irq_unm;
        end else begin : g_wfi
            assign early[k] = irq_any;
        end
        assign sup_hit[k] = (el == EL_LOW) & ~el0_ok[k];
        assign hyp_hit[k] = has_virt & ~secure & ~hyp_mode & hyp_trap[k];
        assign mon_hit[k] = has_sec & (el != EL_HIGH) & mon_trap[k];
    end

    always_comb begin
        verdict.is_wfi    = is_wfi;
        verdict.eat_event = 1'b0;
        verdict.lvl       = LVL_NONE;
        verdict.kind      = RES_SLEEP;
        if (early[is_wfi]) begin
            verdict.kind      = RES_SKIP;
            verdict.eat_event = ~is_wfi & ev_q;
        end else if (sup_hit[is_wfi]) begin
            verdict.kind = RES_TRAP;
            verdict.lvl  = LVL_SUP;
        end else if (hyp_hit[is_wfi]) begin
            verdict.kind = RES_TRAP;
            verdict.lvl  = LVL_HYP;
        end else if (mon_hit[is_wfi]) begin
            verdict.kind = RES_TRAP;
            verdict.lvl  = LVL_MON;
        end
    end

endmodule

// File: rtl/wsc_sleep_fsm.sv
module wsc_sleep_fsm
    import wsc_pkg::*;
#(
    parameter int SYN_W = WSC_SYN_BITS,
    parameter int EC_W  = WSC_EC_BITS
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             instr_valid,
    input  wsc_verdict_t     verdict,
    input  logic             irq_any,
    input  logic             irq_unm,
    input  logic             evt_any,
    output logic             st_idle,
    output logic             st_nap_evt,
    output logic             skip_o,
    output logic             trap_o,
    output logic [1:0]       trap_level_o,
    output logic [SYN_W-1:0] syn_o,
    output logic [EC_W-1:0]  ec_o,
    output logic             sleep_o,
    output logic             abort_clr_o
);

    localparam logic [SYN_W-1:0] SYN_BASE = SYN_W'(WSC_SYN_BASE);
    localparam logic [EC_W-1:0]  EC_VAL   = EC_W'(WSC_EC_WAIT);

    wsc_state_e       st_q;
    logic             low_bit;
    logic [SYN_W-1:0] syn_val;

    assign low_bit = kind_bit(verdict.is_wfi);
    assign syn_val = SYN_BASE | {{(SYN_W-1){1'b0}}, low_bit};

    assign st_idle    = (st_q == ST_AWAKE);
    assign st_nap_evt = (st_q == ST_NAP_EVT);
    assign sleep_o    = (st_q != ST_AWAKE);

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q         <= ST_AWAKE;
            skip_o       <= 1'b0;
            trap_o       <= 1'b0;
            trap_level_o <= '0;
            syn_o        <= '0;
            ec_o         <= '0;
            abort_clr_o  <= 1'b0;
        end else begin
            skip_o       <= 1'b0;
            trap_o       <= 1'b0;
            trap_level_o <= '0;
            syn_o        <= '0;
            ec_o         <= '0;
            abort_clr_o  <= 1'b0;
            unique case (st_q)
                ST_AWAKE: begin
                    if (instr_valid) begin
                        unique case (verdict.kind)
                            RES_SKIP: begin
                                skip_o      <= 1'b1;
                                abort_clr_o <= verdict.is_wfi;
                            end
                            RES_TRAP: begin
                                trap_o       <= 1'b1;
                                trap_level_o <= verdict.lvl;
                                syn_o        <= syn_val;
                                ec_o         <= EC_VAL;
                                abort_clr_o  <= verdict.is_wfi;
                            end
                            default: begin
                                st_q <= verdict.is_wfi ? ST_NAP_IRQ : ST_NAP_EVT;
                            end
                        endcase
                    end
                end
                ST_NAP_EVT: begin
                    if (irq_unm || evt_any) begin
                        st_q <= ST_AWAKE;
                    end
                end
                default: begin
                    if (irq_any) begin
                        st_q        <= ST_AWAKE;
                        abort_clr_o <= 1'b1;
                    end
                end
            endcase
        end
    end

endmodule

// File: rtl/wait_sleep_ctrl.sv
module wait_sleep_ctrl
    import wsc_pkg::*;
#(
    parameter int EL_W  = 2,
    parameter int SYN_W = WSC_SYN_BITS,
    parameter int EC_W  = WSC_EC_BITS
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             instr_valid,
    input  logic             instr_is_wfi,
    input  logic             sev_strobe,
    input  logic             sevl_strobe,
    input  logic             ext_event,
    input  logic [EL_W-1:0]  cur_el,
    input  logic             in_secure,
    input  logic             in_hyp_mode,
    input  logic             virt_present,
    input  logic             sec_present,
    input  logic             el0_wfe_ok,
    input  logic             el0_wfi_ok,
    input  logic             hyp_wfe_trap,
    input  logic             hyp_wfi_trap,
    input  logic             mon_wfe_trap,
    input  logic             mon_wfi_trap,
    input  logic             irq_pend_unmasked,
    input  logic             irq_pend_any,
    output logic             skip_o,
    output logic             trap_o,
    output logic [1:0]       trap_level_o,
    output logic [SYN_W-1:0] trap_syndrome_o,
    output logic [EC_W-1:0]  trap_class_o,
    output logic             sleep_o,
    output logic             event_o,
    output logic             abort_clr_o
);

    wsc_verdict_t verdict;
    logic         evt_any, st_idle, st_nap_evt, consume, absorb;

    assign evt_any = sev_strobe | sevl_strobe | ext_event;
    assign consume = instr_valid & st_idle & verdict.eat_event;
    assign absorb  = st_nap_evt & evt_any;

    wsc_trap_chain #(.EL_W(EL_W)) u_chain (
        .is_wfi   (instr_is_wfi),
        .ev_q     (event_o),
        .irq_unm  (irq_pend_unmasked),
        .irq_any  (irq_pend_any),
        .el       (cur_el),
        .secure   (in_secure),
        .hyp_mode (in_hyp_mode),
        .has_virt (virt_present),
        .has_sec  (sec_present),
        .el0_ok   ({el0_wfi_ok, el0_wfe_ok}),
        .hyp_trap ({hyp_wfi_trap, hyp_wfe_trap}),
        .mon_trap ({mon_wfi_trap, mon_wfe_trap}),
        .verdict  (verdict)
    );

    wsc_event_flag u_flag (
        .clk     (clk),
        .rst     (rst),
        .set_any (evt_any),
        .consume (consume),
        .absorb  (absorb),
        .ev_q    (event_o)
    );

    wsc_sleep_fsm #(.SYN_W(SYN_W), .EC_W(EC_W)) u_fsm (
        .clk          (clk),
        .rst          (rst),
        .instr_valid  (instr_valid),
        .verdict      (verdict),
        .irq_any      (irq_pend_any),
        .irq_unm      (irq_pend_unmasked),
        .evt_any      (evt_any),
        .st_idle      (st_idle),
        .st_nap_evt   (st_nap_evt),
        .skip_o       (skip_o),
        .trap_o       (trap_o),
        .trap_level_o (trap_level_o),
        .syn_o        (trap_syndrome_o),
        .ec_o         (trap_class_o),
        .sleep_o      (sleep_o),
        .abort_clr_o  (abort_clr_o)
    );

endmodule

// File: rtl/wsc_checks.sv
module wsc_checks
    import wsc_pkg::*;
#(
    parameter int EL_W  = 2,
    parameter int SYN_W = WSC_SYN_BITS,
    parameter int EC_W  = WSC_EC_BITS
) (
    input logic             clk,
    input logic             rst,
    input logic             instr_valid,
    input logic             instr_is_wfi,
    input logic             sev_strobe,
    input logic             sevl_strobe,
    input logic             ext_event,
    input logic [EL_W-1:0]  cur_el,
    input logic             el0_wfi_ok,
    input logic             irq_pend_unmasked,
    input logic             irq_pend_any,
    input logic             skip_o,
    input logic             trap_o,
    input logic [1:0]       trap_level_o,
    input logic [SYN_W-1:0] trap_syndrome_o,
    input logic [EC_W-1:0]  trap_class_o,
    input logic             sleep_o,
    input logic             event_o,
    input logic             abort_clr_o
);

    localparam logic [SYN_W-1:0] SYN_REF = SYN_W'(WSC_SYN_BASE);

    logic evts;
    assign evts = sev_strobe | sevl_strobe | ext_event;

    a_r2_consume: assert property (@(posedge clk) disable iff (rst)
        (instr_valid && !instr_is_wfi && event_o && !sleep_o && !evts)
        |=> (skip_o && !event_o));

    a_r4_wfi_skip: assert property (@(posedge clk) disable iff (rst)
        (instr_valid && instr_is_wfi && irq_pend_any && !sleep_o)
        |=> (skip_o && abort_clr_o));

    a_r5_sup_first: assert property (@(posedge clk) disable iff (rst)
        (instr_valid && instr_is_wfi && !sleep_o && !irq_pend_any
         && cur_el == '0 && !el0_wfi_ok)
        |=> (trap_o && trap_level_o == 2'd1));

    a_r8_syndrome: assert property (@(posedge clk) disable iff (rst)
        trap_o |-> (trap_syndrome_o[SYN_W-1:1] == SYN_REF[SYN_W-1:1]
                    && trap_class_o == EC_W'(WSC_EC_WAIT)));

    a_r8_quiet: assert property (@(posedge clk) disable iff (rst)
        !trap_o |-> (trap_syndrome_o == '0 && trap_class_o == '0
                     && trap_level_o == 2'd0));

    a_r9_hold: assert property (@(posedge clk) disable iff (rst)
        (sleep_o && !irq_pend_any && !irq_pend_unmasked && !evts)
        |=> (sleep_o && !skip_o && !trap_o));

    a_r10_wake: assert property (@(posedge clk) disable iff (rst)
        (sleep_o && irq_pend_unmasked) |=> !sleep_o);

    a_r11_set: assert property (@(posedge clk) disable iff (rst)
        (sevl_strobe && !sleep_o) |=> event_o);

    a_r12_awake: assert property (@(posedge clk) disable iff (rst)
        abort_clr_o |-> !sleep_o);

    a_r13_exclusive: assert property (@(posedge clk) disable iff (rst)
        (skip_o || trap_o) |-> (!sleep_o && !(skip_o && trap_o)));

endmodule

bind wait_sleep_ctrl wsc_checks #(.EL_W(EL_W), .SYN_W(SYN_W), .EC_W(EC_W)) u_checks (
    .clk               (clk),
    .rst               (rst),
    .instr_valid       (instr_valid),
    .instr_is_wfi      (instr_is_wfi),
    .sev_strobe        (sev_strobe),
    .sevl_strobe       (sevl_strobe),
    .ext_event         (ext_event),
    .cur_el            (cur_el),
    .el0_wfi_ok        (el0_wfi_ok),
    .irq_pend_unmasked (irq_pend_unmasked),
    .irq_pend_any      (irq_pend_any),
    .skip_o            (skip_o),
    .trap_o            (trap_o),
    .trap_level_o      (trap_level_o),
    .trap_syndrome_o   (trap_syndrome_o),
    .trap_class_o      (trap_class_o),
    .sleep_o           (sleep_o),
    .event_o           (event_o),
    .abort_clr_o       (abort_clr_o)
);

// File: tb/wait_sleep_ctrl_tb_top.sv
`timescale 1ns/1ps
module wait_sleep_ctrl_tb_top;

    typedef struct packed {
        logic       valid, wfi, sev, sevl, ext;
        logic [1:0] el;
        logic       sec_st, hypm, virt, secp;
        logic       ok_e, ok_i, ht_e, ht_i, mt_e, mt_i, unm, any;
    } stim_t;

    typedef struct packed {
        logic        skip, trap;
        logic [1:0]  lvl;
        logic [24:0] syn;
        logic [5:0]  ec;
        logic        sleep, ev, abrt;
    } exp_t;

    logic clk = 1'b0;
    logic rst = 1'b1;
    stim_t cur = '0;

    logic        skip_o, trap_o, sleep_o, event_o, abort_clr_o;
    logic [1:0]  trap_level_o;
    logic [24:0] trap_syndrome_o;
    logic [5:0]  trap_class_o;

    int n_chk = 0;
    int n_bad = 0;
    int cyc = 0;
    bit finished = 1'b0;

    exp_t  exp_q[$];
    string tag_q[$];
    int    due_q[$];

    int m_st = 0;
    logic m_ev = 1'b0;

    always #10 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    wait_sleep_ctrl dut_i (
        .clk(clk), .rst(rst),
        .instr_valid(cur.valid), .instr_is_wfi(cur.wfi),
        .sev_strobe(cur.sev), .sevl_strobe(cur.sevl), .ext_event(cur.ext),
        .cur_el(cur.el), .in_secure(cur.sec_st), .in_hyp_mode(cur.hypm),
        .virt_present(cur.virt), .sec_present(cur.secp),
        .el0_wfe_ok(cur.ok_e), .el0_wfi_ok(cur.ok_i),
        .hyp_wfe_trap(cur.ht_e), .hyp_wfi_trap(cur.ht_i),
        .mon_wfe_trap(cur.mt_e), .mon_wfi_trap(cur.mt_i),
        .irq_pend_unmasked(cur.unm), .irq_pend_any(cur.any),
        .skip_o(skip_o), .trap_o(trap_o), .trap_level_o(trap_level_o),
        .trap_syndrome_o(trap_syndrome_o), .trap_class_o(trap_class_o),
        .sleep_o(sleep_o), .event_o(event_o), .abort_clr_o(abort_clr_o)
    );

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    endtask

    task automatic step(input stim_t s, input string tag);
        exp_t e;
        logic evt, skip, trap, consume;
        logic [1:0] lvl;
        int nst;
        @(negedge clk);
        cur = s;
        evt = s.sev | s.sevl | s.ext;
        e = '0;
        skip = 1'b0; trap = 1'b0; lvl = 2'd0; consume = 1'b0;
        nst = m_st;
        if (m_st == 0) begin
            if (s.valid) begin
                if (!s.wfi && m_ev) begin skip = 1'b1; consume = 1'b1; end
                else if (!s.wfi && s.unm) skip = 1'b1;
                else if (s.wfi && s.any) skip = 1'b1;
                else if (s.el == 2'd0 && !(s.wfi ? s.ok_i : s.ok_e)) begin trap = 1'b1; lvl = 2'd1; end
                else if (s.virt && !s.sec_st && !s.hypm && (s.wfi ? s.ht_i : s.ht_e)) begin trap = 1'b1; lvl = 2'd2; end
                else if (s.secp && s.el != 2'd3 && (s.wfi ? s.mt_i : s.mt_e)) begin trap = 1'b1; lvl = 2'd3; end
                else nst = s.wfi ? 2 : 1;
                e.abrt = s.wfi && (nst == 0);
            end
        end else if (m_st == 1) begin
            if (s.unm || evt) nst = 0;
        end else begin
            if (s.any) begin nst = 0; e.abrt = 1'b1; end
        end
        if (m_st == 1 && evt) m_ev = 1'b0;
        else if (evt) m_ev = 1'b1;
        else if (consume) m_ev = 1'b0;
        m_st = nst;
        e.skip = skip; e.trap = trap; e.lvl = lvl;
        e.syn = trap ? (25'h1E0_0000 | {24'd0, ~s.wfi}) : 25'd0;
        e.ec = trap ? 6'h01 : 6'h00;
        e.sleep = (m_st != 0);
        e.ev = m_ev;
        exp_q.push_back(e);
        tag_q.push_back(tag);
        due_q.push_back(cyc + 1);
    endtask

    // Monitor: compares each expected item in the cycle its result is visible
    always @(negedge clk) begin
        if (!rst && due_q.size() > 0 && due_q[0] == cyc) begin
            exp_t e, a;
            string t;
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            void'(due_q.pop_front());
            a = {skip_o, trap_o, trap_level_o, trap_syndrome_o, trap_class_o,
                 sleep_o, event_o, abort_clr_o};
            n_chk++;
            if (a !== e) begin
                n_bad++;
                $display("FAIL %s actual=%h expected=%h", t, a, e);
            end
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            n_bad++;
            $display("FAIL R13 watchdog actual=hung expected=finished");
            summary();
            $finish;
        end
    end

    initial begin
        stim_t s;
        stim_t base;
        logic [31:0] r;
        base = '0;
        base.el = 2'd1; base.ok_e = 1'b1; base.ok_i = 1'b1;
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R1: reset values
        n_chk++;
        if ({skip_o, trap_o, trap_level_o, trap_syndrome_o, trap_class_o,
             sleep_o, event_o, abort_clr_o} !== '0) begin
            n_bad++;
            $display("FAIL R1 actual=%b%b%h%h%h%b%b%b expected=0", skip_o, trap_o,
                     trap_level_o, trap_syndrome_o, trap_class_o, sleep_o, event_o, abort_clr_o);
        end
        rst = 1'b0;
        step(base, "R1");

        s = base; s.sevl = 1'b1; step(s, "R11");
        // R2: event set wins over a supervisor trap condition
        s = base; s.valid = 1'b1; s.el = 2'd0; s.ok_e = 1'b0; step(s, "R2");
        s = base; s.valid = 1'b1; s.unm = 1'b1; s.any = 1'b1; step(s, "R3");
        // R3: masked-only pending does not stop WFE -> sleep
        s = base; s.valid = 1'b1; s.any = 1'b1; step(s, "R3");
        s = base; s.valid = 1'b1; s.wfi = 1'b1; step(s, "R9");
        s = base; step(s, "R9");
        s = base; s.ext = 1'b1; step(s, "R10");
        s = base; step(s, "R10");
        s = base; s.valid = 1'b1; s.wfi = 1'b1; s.any = 1'b1; step(s, "R4");
        // R5: supervisor wins over hypervisor
        s = base; s.valid = 1'b1; s.el = 2'd0; s.ok_e = 1'b0; s.virt = 1'b1; s.ht_e = 1'b1; step(s, "R5");
        s = base; s.valid = 1'b1; s.wfi = 1'b1; s.el = 2'd0; s.ok_i = 1'b0; step(s, "R5");
        s = base; s.valid = 1'b1; s.wfi = 1'b1; s.virt = 1'b1; s.ht_i = 1'b1; s.secp = 1'b1; s.mt_i = 1'b1; step(s, "R6");
        s = base; s.valid = 1'b1; s.virt = 1'b1; s.ht_e = 1'b1; s.sec_st = 1'b1; s.secp = 1'b1; s.mt_e = 1'b1; step(s, "R7");
        s = base; s.valid = 1'b1; s.wfi = 1'b1; s.secp = 1'b1; s.mt_i = 1'b1; step(s, "R8");
        // R7: monitor trap not taken at the top level -> WFE sleep, woken by sev
        s = base; s.valid = 1'b1; s.el = 2'd3; s.secp = 1'b1; s.mt_e = 1'b1; step(s, "R7");
        s = base; s.sev = 1'b1; step(s, "R10");
        s = base; s.valid = 1'b1; s.wfi = 1'b1; s.virt = 1'b1; s.hypm = 1'b1; s.ht_i = 1'b1; step(s, "R6");
        s = base; s.sev = 1'b1; step(s, "R11");
        s = base; s.any = 1'b1; step(s, "R12");
        // R11: set wins over same-cycle consume
        s = base; s.valid = 1'b1; s.sev = 1'b1; step(s, "R11");
        s = base; s.valid = 1'b1; s.unm = 1'b1; s.any = 1'b1; s.ext = 1'b1; step(s, "R11");
        s = base; s.valid = 1'b1; step(s, "R2");
        s = base; s.valid = 1'b1; step(s, "R9");
        s = base; s.unm = 1'b1; s.any = 1'b1; step(s, "R10");

        r = 32'hACE1_2345;
        for (int i = 0; i < 120; i++) begin
            r = {r[30:0], r[31] ^ r[21] ^ r[1] ^ r[0]};
            s = '0;
            s.valid = r[0] | r[1]; s.wfi = r[2]; s.el = r[4:3];
            s.sec_st = r[5]; s.hypm = r[6]; s.virt = r[7]; s.secp = r[8];
            s.ok_e = r[9]; s.ok_i = r[10]; s.ht_e = r[11]; s.ht_i = r[12];
            s.mt_e = r[13]; s.mt_i = r[14];
            s.unm = r[15] & r[16]; s.any = s.unm | (r[17] & r[18]);
            s.sev = r[19] & r[20] & r[21]; s.sevl = r[22] & r[23] & r[24];
            s.ext = r[25] & r[26] & r[27];
            step(s, "R13");
        end
        step(base, "R13");
        repeat (3) @(negedge clk);
        finished = 1'b1;
        summary();
        $finish;
    end

endmodule